// File: doc/BRIEF.md
# Two-Level Interrupt Accumulator Dispatcher

This block collects interrupt sources from a set of peripheral accumulators and hands them out one at a time as packed identifiers. Every accumulator holds up to eight latched sources, a single enable bit and per-source trigger configuration. An accumulator counts as pending when it is enabled and has at least one latched source. Its pending bit sits in a 32-bit owner word: accumulator number = 32 × word index + bit position.

A scan engine walks the owner words and visits only the words that can hold a registered accumulator. That range runs from the lowest registered accumulator's word to the highest registered accumulator's word. Inside each word it takes a snapshot and services accumulators from the lowest set bit upward. Inside each accumulator it takes a snapshot of the latched sources and emits them from source 0 upward. After the last word in the range it starts again at the first word.

Software registers each accumulator with a 4-bit slave id and an 8-bit peripheral number. Registration widens the scan bounds. Software acknowledges a source by writing a one-hot clear mask.

Identifiers leave on a valid/ready stream. While `id_valid_o` is high and `id_ready_i` is low, the identifier is held unchanged. Exactly one identifier is consumed per cycle in which both are high. The control inputs (raise, clear, enable, register, configure) are plain single-cycle strobes.

Top module: `irq_acc_dispatch`

## Requirements
- R1: After reset all latches, enables and configuration bits are 0, the bounds are max = 0 and min = NUM_ACC-1, `id_valid_o` is low, and nothing is emitted while no accumulator has been registered.
- R2: An accumulator is serviced only while its enable bit is 1 and it holds a latched source. An enable write with value 1 sets the bit only if it is clear, and a write with value 0 clears it only if it is set. A source latched while the enable bit is 0 is emitted once the bit is set.
- R3: A registration for accumulator A sets max = A if A > max and min = A if A < min. The scan visits only words min>>5 through max>>5, so pending accumulators outside that word range are never emitted.
- R4: Within one word snapshot, accumulators are emitted in ascending number. Within one accumulator snapshot, sources are emitted in ascending source number.
- R5: `id_o` carries 0 in bits 31:28, the slave id in 27:24, the peripheral number in 23:16, the source number in 15:8 and the accumulator number in 7:0. An accumulator that was never registered reports slave 0 and peripheral 0.
- R6: While `id_valid_o` is high and `id_ready_i` is low, `id_valid_o` stays high and `id_o` stays stable. One identifier is consumed per handshake.
- R7: A clear write removes the latched sources whose bits are 1 in `clr_mask_i`, and a cleared source is not emitted. When a raise and a clear hit the same source in the same cycle, the raise wins.
- R8: After the last word in range, the scan restarts at the first word, so a source that is still latched is emitted again.
- R9: A configuration write stores edge (1 = edge, 0 = level), high-polarity and low-polarity bits for one source, and `cfg_q_o` reads back {edge, high, low}. A level write with both polarities set is rejected: storage is unchanged and `cfg_err_o` pulses in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| raise_i | input | 1 | Latch one source |
| raise_acc_i | input | log2(NUM_ACC) | Accumulator of the raised source |
| raise_sel_i | input | log2(SRC_N) | Source number to latch |
| clr_wr_i | input | 1 | Clear write strobe |
| clr_acc_i | input | log2(NUM_ACC) | Accumulator to clear |
| clr_mask_i | input | SRC_N | Write-one-to-clear source mask |
| en_wr_i | input | 1 | Enable write strobe |
| en_acc_i | input | log2(NUM_ACC) | Accumulator whose enable is written |
| en_val_i | input | 1 | 1 unmasks, 0 masks |
| reg_wr_i | input | 1 | Register accumulator strobe |
| reg_acc_i | input | log2(NUM_ACC) | Accumulator being registered |
| reg_sid_i | input | 4 | Slave id for that accumulator |
| reg_per_i | input | 8 | Peripheral number for that accumulator |
| cfg_wr_i | input | 1 | Trigger configuration write strobe |
| cfg_acc_i | input | log2(NUM_ACC) | Accumulator for configuration write and readback |
| cfg_sel_i | input | log2(SRC_N) | Source for configuration write and readback |
| cfg_edge_i | input | 1 | 1 = edge, 0 = level |
| cfg_hi_i | input | 1 | Rising / high polarity |
| cfg_lo_i | input | 1 | Falling / low polarity |
| cfg_q_o | output | 3 | Stored {edge, high, low} of the addressed source |
| cfg_err_o | output | 1 | Rejected configuration write, one cycle later |
| id_valid_o | output | 1 | Identifier available |
| id_ready_i | input | 1 | Consumer accepts the identifier |
| id_o | output | 32 | Packed interrupt identifier |

## Verification
The bench builds the block with NUM_ACC = 64 and SRC_N = 8. That gives two owner words, so the word-range bound, the wrap from the last word back to the first, and the exclusion of an unregistered word can all be reached within a short run. At this size every one of the 512 accumulator/source pairs can be raised one by one, with its packed identifier computed arithmetically in the bench. Ordering is checked by making a whole word pending before the first registration, so that the first scan sees the word in one snapshot.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
  localparam int WORD_BITS = 32;
  localparam int WORD_SH   = 5;

  typedef enum logic [1:0] {
    SC_LOAD,
    SC_PICK_ACC,
    SC_PICK_SRC,
    SC_EMIT
  } scan_st_e;

  function automatic logic [31:0] pack_id(input logic [3:0] sid, input logic [7:0] per,
                                          input logic [7:0] src, input logic [7:0] acc);
    return {4'h0, sid, per, src, acc};
  endfunction
endpackage

// File: rtl/irqd_src_bank.sv
module irqd_src_bank import irqd_pkg::*; #(
  parameter int NUM_ACC = 256,
  parameter int SRC_N   = 8,
  parameter int ACC_W   = $clog2(NUM_ACC),
  parameter int SRC_W   = $clog2(SRC_N)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               raise_i,
  input  logic [ACC_W-1:0]   raise_acc_i,
  input  logic [SRC_W-1:0]   raise_sel_i,
  input  logic               clr_wr_i,
  input  logic [ACC_W-1:0]   clr_acc_i,
  input  logic [SRC_N-1:0]   clr_mask_i,
  input  logic               en_wr_i,
  input  logic [ACC_W-1:0]   en_acc_i,
  input  logic               en_val_i,
  input  logic               cfg_wr_i,
  input  logic [ACC_W-1:0]   cfg_acc_i,
  input  logic [SRC_W-1:0]   cfg_sel_i,
  input  logic               cfg_edge_i,
  input  logic               cfg_hi_i,
  input  logic               cfg_lo_i,
  output logic [2:0]         cfg_q_o,
  output logic               cfg_err_o,
  input  logic [ACC_W-1:0]   look_acc_i,
  output logic [SRC_N-1:0]   look_lat_o,
  output logic [NUM_ACC-1:0] pend_o
);
  logic [SRC_N-1:0] lat_all [NUM_ACC];
  logic [SRC_N-1:0] typ_all [NUM_ACC];
  logic [SRC_N-1:0] hi_all  [NUM_ACC];
  logic [SRC_N-1:0] lo_all  [NUM_ACC];
  logic             cfg_legal;
  logic             cfg_err_q;

  // level trigger with both polarities is not a valid combination
  assign cfg_legal = cfg_edge_i | ~(cfg_hi_i & cfg_lo_i);

  for (genvar a = 0; a < NUM_ACC; a++) begin : g_acc
    logic [SRC_N-1:0] lat_r, typ_r, hi_r, lo_r;
    logic [SRC_N-1:0] set_m, clr_m, cfg_m;
    logic             en_r;
    logic             hit_raise, hit_clr, hit_en, hit_cfg;

    assign hit_raise = raise_i  && (raise_acc_i == ACC_W'(a));
    assign hit_clr   = clr_wr_i && (clr_acc_i   == ACC_W'(a));
    assign hit_en    = en_wr_i  && (en_acc_i    == ACC_W'(a));
    assign hit_cfg   = cfg_wr_i && (cfg_acc_i   == ACC_W'(a)) && cfg_legal;

    assign set_m = hit_raise ? (SRC_N'(1) << raise_sel_i) : '0;
    assign clr_m = hit_clr ? clr_mask_i : '0;
    assign cfg_m = hit_cfg ? (SRC_N'(1) << cfg_sel_i) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lat_r <= '0;
        en_r  <= 1'b0;
        typ_r <= '0;
        hi_r  <= '0;
        lo_r  <= '0;
      end else begin
        // a raise in the same cycle as a clear keeps the source latched
        lat_r <= (lat_r & ~clr_m) | set_m;
        if (hit_en) begin
          if (en_val_i && !en_r)      en_r <= 1'b1;
          else if (!en_val_i && en_r) en_r <= 1'b0;
        end
        typ_r <= (typ_r & ~cfg_m) | (cfg_edge_i ? cfg_m : '0);
        hi_r  <= (hi_r  & ~cfg_m) | (cfg_hi_i   ? cfg_m : '0);
        lo_r  <= (lo_r  & ~cfg_m) | (cfg_lo_i   ? cfg_m : '0);
      end
    end

    assign lat_all[a] = lat_r;
    assign typ_all[a] = typ_r;
    assign hi_all[a]  = hi_r;
    assign lo_all[a]  = lo_r;
    assign pend_o[a]  = en_r & (|lat_r);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_err_q <= 1'b0;
    else         cfg_err_q <= cfg_wr_i & ~cfg_legal;
  end

  assign cfg_err_o  = cfg_err_q;
  assign cfg_q_o    = {typ_all[cfg_acc_i][cfg_sel_i], hi_all[cfg_acc_i][cfg_sel_i],
                       lo_all[cfg_acc_i][cfg_sel_i]};
  assign look_lat_o = lat_all[look_acc_i];
endmodule

// File: rtl/irqd_reg_table.sv
module irqd_reg_table import irqd_pkg::*; #(
  parameter int NUM_ACC = 256,
  parameter int ACC_W   = $clog2(NUM_ACC),
  parameter int WIDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ACC_W-1:0]  reg_acc_i,
  input  logic [3:0]        reg_sid_i,
  input  logic [7:0]        reg_per_i,
  input  logic [ACC_W-1:0]  look_acc_i,
  output logic [3:0]        look_sid_o,
  output logic [7:0]        look_per_o,
  output logic [ACC_W-1:0]  min_acc_o,
  output logic [ACC_W-1:0]  max_acc_o,
  output logic [WIDX_W-1:0] first_word_o,
  output logic [WIDX_W-1:0] last_word_o,
  output logic              range_ok_o
);
  logic [3:0]       sid_all [NUM_ACC];
  logic [7:0]       per_all [NUM_ACC];
  logic [ACC_W-1:0] min_q, max_q;

  for (genvar a = 0; a < NUM_ACC; a++) begin : g_ent
    logic [3:0] sid_r;
    logic [7:0] per_r;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sid_r <= '0;
        per_r <= '0;
      end else if (reg_wr_i && reg_acc_i == ACC_W'(a)) begin
        sid_r <= reg_sid_i;
        per_r <= reg_per_i;
      end
    end
    assign sid_all[a] = sid_r;
    assign per_all[a] = per_r;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      min_q <= ACC_W'(NUM_ACC - 1);
      max_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_acc_i < min_q) min_q <= reg_acc_i;
      if (reg_acc_i > max_q) max_q <= reg_acc_i;
    end
  end

  assign look_sid_o   = sid_all[look_acc_i];
  assign look_per_o   = per_all[look_acc_i];
  assign min_acc_o    = min_q;
  assign max_acc_o    = max_q;
  assign first_word_o = WIDX_W'(min_q >> WORD_SH);
  assign last_word_o  = WIDX_W'(max_q >> WORD_SH);
  assign range_ok_o   = (max_q >= min_q);
endmodule

// File: rtl/irqd_scan.sv
module irqd_scan import irqd_pkg::*; #(
  parameter int NUM_ACC = 256,
  parameter int SRC_N   = 8,
  parameter int ACC_W   = $clog2(NUM_ACC),
  parameter int SRC_W   = $clog2(SRC_N),
  parameter int WIDX_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ACC-1:0] pend_i,
  input  logic [WIDX_W-1:0]  first_word_i,
  input  logic [WIDX_W-1:0]  last_word_i,
  input  logic               range_ok_i,
  output logic [ACC_W-1:0]   look_acc_o,
  input  logic [SRC_N-1:0]   look_lat_i,
  input  logic [3:0]         look_sid_i,
  input  logic [7:0]         look_per_i,
  input  logic               id_ready_i,
  output logic               id_valid_o,
  output logic [31:0]        id_o
);
  scan_st_e               st_q;
  logic [WIDX_W-1:0]      word_q;
  logic [WORD_BITS-1:0]   wcopy_q, word_view;
  logic [SRC_N-1:0]       scopy_q;
  logic [ACC_W-1:0]       acc_q, acc_nxt;
  logic [WORD_SH-1:0]     bit_sel;
  logic [SRC_W-1:0]       src_sel;
  logic [31:0]            id_q;
  logic                   word_out;

  assign word_view = pend_i[int'(word_q)*WORD_BITS +: WORD_BITS];
  assign word_out  = (word_q < first_word_i) || (word_q > last_word_i);

  // lowest set bit of the word snapshot
  always_comb begin
    bit_sel = '0;
    for (int i = WORD_BITS - 1; i >= 0; i--)
      if (wcopy_q[i]) bit_sel = WORD_SH'(i);
  end

  // lowest set bit of the source snapshot
  always_comb begin
    src_sel = '0;
    for (int i = SRC_N - 1; i >= 0; i--)
      if (scopy_q[i]) src_sel = SRC_W'(i);
  end

  assign acc_nxt    = ACC_W'(int'(word_q) * WORD_BITS + int'(bit_sel));
  assign look_acc_o = (st_q == SC_PICK_ACC) ? acc_nxt : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SC_LOAD;
      word_q  <= '0;
      wcopy_q <= '0;
      scopy_q <= '0;
      acc_q   <= '0;
      id_q    <= '0;
    end else begin
      unique case (st_q)
        SC_LOAD: begin
          if (range_ok_i) begin
            if (word_out) begin
              word_q <= first_word_i;
            end else begin
              wcopy_q <= word_view;
              st_q    <= SC_PICK_ACC;
            end
          end
        end
        SC_PICK_ACC: begin
          if (wcopy_q == '0) begin
            word_q <= (word_q >= last_word_i) ? first_word_i : word_q + 1'b1;
            st_q   <= SC_LOAD;
          end else begin
            acc_q            <= acc_nxt;
            wcopy_q[bit_sel] <= 1'b0;
            scopy_q          <= look_lat_i;
            st_q             <= SC_PICK_SRC;
          end
        end
        SC_PICK_SRC: begin
          if (scopy_q == '0) begin
            st_q <= SC_PICK_ACC;
          end else begin
            scopy_q[src_sel] <= 1'b0;
            id_q <= pack_id(look_sid_i, look_per_i, 8'(src_sel), 8'(acc_q));
            st_q <= SC_EMIT;
          end
        end
        SC_EMIT: begin
          if (id_ready_i) st_q <= SC_PICK_SRC;
        end
        default: st_q <= SC_LOAD;
      endcase
    end
  end

  assign id_valid_o = (st_q == SC_EMIT);
  assign id_o       = id_q;
endmodule

// File: rtl/irq_acc_dispatch.sv
module irq_acc_dispatch import irqd_pkg::*; #(
  parameter int NUM_ACC = 256,
  parameter int SRC_N   = 8,
  parameter int ACC_W   = $clog2(NUM_ACC),
  parameter int SRC_W   = $clog2(SRC_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raise_i,
  input  logic [ACC_W-1:0] raise_acc_i,
  input  logic [SRC_W-1:0] raise_sel_i,
  input  logic             clr_wr_i,
  input  logic [ACC_W-1:0] clr_acc_i,
  input  logic [SRC_N-1:0] clr_mask_i,
  input  logic             en_wr_i,
  input  logic [ACC_W-1:0] en_acc_i,
  input  logic             en_val_i,
  input  logic             reg_wr_i,
  input  logic [ACC_W-1:0] reg_acc_i,
  input  logic [3:0]       reg_sid_i,
  input  logic [7:0]       reg_per_i,
  input  logic             cfg_wr_i,
  input  logic [ACC_W-1:0] cfg_acc_i,
  input  logic [SRC_W-1:0] cfg_sel_i,
  input  logic             cfg_edge_i,
  input  logic             cfg_hi_i,
  input  logic             cfg_lo_i,
  output logic [2:0]       cfg_q_o,
  output logic             cfg_err_o,
  output logic             id_valid_o,
  input  logic             id_ready_i,
  output logic [31:0]      id_o
);
  localparam int WORDS  = NUM_ACC / WORD_BITS;
  localparam int WIDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

  logic [NUM_ACC-1:0] pend;
  logic [ACC_W-1:0]   look_acc;
  logic [SRC_N-1:0]   look_lat;
  logic [3:0]         look_sid;
  logic [7:0]         look_per;
  logic [ACC_W-1:0]   min_acc, max_acc;
  logic [WIDX_W-1:0]  first_word, last_word;
  logic               range_ok;

  irqd_src_bank #(.NUM_ACC(NUM_ACC), .SRC_N(SRC_N), .ACC_W(ACC_W), .SRC_W(SRC_W)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .raise_i(raise_i), .raise_acc_i(raise_acc_i), .raise_sel_i(raise_sel_i),
    .clr_wr_i(clr_wr_i), .clr_acc_i(clr_acc_i), .clr_mask_i(clr_mask_i),
    .en_wr_i(en_wr_i), .en_acc_i(en_acc_i), .en_val_i(en_val_i),
    .cfg_wr_i(cfg_wr_i), .cfg_acc_i(cfg_acc_i), .cfg_sel_i(cfg_sel_i),
    .cfg_edge_i(cfg_edge_i), .cfg_hi_i(cfg_hi_i), .cfg_lo_i(cfg_lo_i),
    .cfg_q_o(cfg_q_o), .cfg_err_o(cfg_err_o),
    .look_acc_i(look_acc), .look_lat_o(look_lat), .pend_o(pend)
  );

  irqd_reg_table #(.NUM_ACC(NUM_ACC), .ACC_W(ACC_W), .WIDX_W(WIDX_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_wr_i(reg_wr_i), .reg_acc_i(reg_acc_i), .reg_sid_i(reg_sid_i), .reg_per_i(reg_per_i),
    .look_acc_i(look_acc), .look_sid_o(look_sid), .look_per_o(look_per),
    .min_acc_o(min_acc), .max_acc_o(max_acc),
    .first_word_o(first_word), .last_word_o(last_word), .range_ok_o(range_ok)
  );

  irqd_scan #(.NUM_ACC(NUM_ACC), .SRC_N(SRC_N), .ACC_W(ACC_W), .SRC_W(SRC_W),
              .WIDX_W(WIDX_W)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .pend_i(pend), .first_word_i(first_word), .last_word_i(last_word), .range_ok_i(range_ok),
    .look_acc_o(look_acc), .look_lat_i(look_lat), .look_sid_i(look_sid), .look_per_i(look_per),
    .id_ready_i(id_ready_i), .id_valid_o(id_valid_o), .id_o(id_o)
  );
endmodule

// File: rtl/irq_acc_dispatch_chk.sv
module irq_acc_dispatch_chk #(
  parameter int NUM_ACC = 256,
  parameter int SRC_N   = 8,
  parameter int ACC_W   = $clog2(NUM_ACC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             id_valid_o,
  input logic             id_ready_i,
  input logic [31:0]      id_o,
  input logic             cfg_wr_i,
  input logic             cfg_edge_i,
  input logic             cfg_hi_i,
  input logic             cfg_lo_i,
  input logic             cfg_err_o,
  input logic [ACC_W-1:0] min_acc,
  input logic [ACC_W-1:0] max_acc
);
  // R6
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o && !id_ready_i |=> id_valid_o && $stable(id_o));

  // R3
  word_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> (int'(id_o[7:5]) >= int'(min_acc >> 5)) &&
                   (int'(id_o[7:5]) <= int'(max_acc >> 5)));

  // R1
  unarmed_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (max_acc < min_acc) |-> !id_valid_o);

  // R5
  id_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> (id_o[31:28] == 4'h0) && (int'(id_o[15:8]) < SRC_N) &&
                   (int'(id_o[7:0]) < NUM_ACC));

  // R9
  reject_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> $past(cfg_wr_i) && !$past(cfg_edge_i) && $past(cfg_hi_i) && $past(cfg_lo_i));
endmodule

bind irq_acc_dispatch irq_acc_dispatch_chk #(.NUM_ACC(NUM_ACC), .SRC_N(SRC_N), .ACC_W(ACC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .id_valid_o(id_valid_o), .id_ready_i(id_ready_i), .id_o(id_o),
  .cfg_wr_i(cfg_wr_i), .cfg_edge_i(cfg_edge_i), .cfg_hi_i(cfg_hi_i), .cfg_lo_i(cfg_lo_i),
  .cfg_err_o(cfg_err_o), .min_acc(min_acc), .max_acc(max_acc)
);

// File: tb/test_irq_acc_dispatch.sv
module test_irq_acc_dispatch;
  localparam int NA = 64;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic raise_i = 0;        logic [AW-1:0] raise_acc_i = '0; logic [2:0] raise_sel_i = '0;
  logic clr_wr_i = 0;       logic [AW-1:0] clr_acc_i = '0;   logic [7:0] clr_mask_i = '0;
  logic en_wr_i = 0;        logic [AW-1:0] en_acc_i = '0;    logic en_val_i = 0;
  logic reg_wr_i = 0;       logic [AW-1:0] reg_acc_i = '0;   logic [3:0] reg_sid_i = '0;
  logic [7:0] reg_per_i = '0;
  logic cfg_wr_i = 0;       logic [AW-1:0] cfg_acc_i = '0;   logic [2:0] cfg_sel_i = '0;
  logic cfg_edge_i = 0, cfg_hi_i = 0, cfg_lo_i = 0;
  logic [2:0] cfg_q_o;
  logic cfg_err_o, id_valid_o;
  logic id_ready_i = 0;
  logic [31:0] id_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [3:0] sid_m [NA];
  logic [7:0] per_m [NA];

  always #5 clk = ~clk;

  irq_acc_dispatch #(.NUM_ACC(NA), .SRC_N(8)) i_irq_acc_dispatch (
    .clk_i(clk), .rst_ni(rst_ni),
    .raise_i(raise_i), .raise_acc_i(raise_acc_i), .raise_sel_i(raise_sel_i),
    .clr_wr_i(clr_wr_i), .clr_acc_i(clr_acc_i), .clr_mask_i(clr_mask_i),
    .en_wr_i(en_wr_i), .en_acc_i(en_acc_i), .en_val_i(en_val_i),
    .reg_wr_i(reg_wr_i), .reg_acc_i(reg_acc_i), .reg_sid_i(reg_sid_i), .reg_per_i(reg_per_i),
    .cfg_wr_i(cfg_wr_i), .cfg_acc_i(cfg_acc_i), .cfg_sel_i(cfg_sel_i),
    .cfg_edge_i(cfg_edge_i), .cfg_hi_i(cfg_hi_i), .cfg_lo_i(cfg_lo_i),
    .cfg_q_o(cfg_q_o), .cfg_err_o(cfg_err_o),
    .id_valid_o(id_valid_o), .id_ready_i(id_ready_i), .id_o(id_o)
  );

  function automatic logic [31:0] exp_id(input int a, input int s);
    return {4'h0, sid_m[a], per_m[a], 8'(s), 8'(a)};
  endfunction

  function automatic logic [7:0] pat(input int a);
    logic [7:0] m;
    m = 8'((a * 37) ^ 90);
    return (m == 8'h00) ? 8'h01 : m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic raise(input int a, input int s);
    raise_i = 1; raise_acc_i = AW'(a); raise_sel_i = 3'(s);
    @(negedge clk); raise_i = 0;
  endtask

  task automatic set_en(input int a, input bit v);
    en_wr_i = 1; en_acc_i = AW'(a); en_val_i = v;
    @(negedge clk); en_wr_i = 0;
  endtask

  task automatic do_reg(input int a, input int sid, input int per);
    reg_wr_i = 1; reg_acc_i = AW'(a); reg_sid_i = 4'(sid); reg_per_i = 8'(per);
    sid_m[a] = 4'(sid); per_m[a] = 8'(per);
    @(negedge clk); reg_wr_i = 0;
  endtask

  task automatic clr(input int a, input logic [7:0] m);
    clr_wr_i = 1; clr_acc_i = AW'(a); clr_mask_i = m;
    @(negedge clk); clr_wr_i = 0;
  endtask

  task automatic wait_valid(output bit seen, input int limit);
    seen = 0;
    for (int i = 0; i < limit; i++) begin
      if (id_valid_o) begin seen = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic idle_for(input int n, output bit quiet);
    quiet = 1;
    for (int i = 0; i < n; i++) begin
      if (id_valid_o) quiet = 0;
      @(negedge clk);
    end
  endtask

  task automatic take(output logic [31:0] got, input bit do_clr);
    got = id_o; id_ready_i = 1;
    @(negedge clk); id_ready_i = 0;
    if (do_clr) clr(int'(got[AW-1:0]), 8'(1) << got[10:8]);
  endtask

  task automatic cfg_write(input bit e, input bit h, input bit l);
    cfg_acc_i = 6'd5; cfg_sel_i = 3'd3; cfg_edge_i = e; cfg_hi_i = h; cfg_lo_i = l; cfg_wr_i = 1;
    @(negedge clk); cfg_wr_i = 0;
  endtask

  task automatic expect_one(input logic [31:0] exp, input bit do_clr, input string req);
    bit seen;
    logic [31:0] got;
    wait_valid(seen, 300);
    chk(seen, {req, " valid"}, {31'b0, seen}, 32'd1);
    if (seen) begin
      take(got, do_clr);
      chk(got == exp, {req, " id"}, got, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit quiet;
    logic [31:0] exps [64];
    int n;
    int word1 [4];
    int word0 [2];
    logic [2:0] cur;
    word1 = '{33, 40, 47, 63};
    word0 = '{2, 17};
    for (int a = 0; a < NA; a++) begin sid_m[a] = '0; per_m[a] = '0; end
    repeat (4) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R1: reset state
    chk(!id_valid_o, "R1 valid after reset", {31'b0, id_valid_o}, 0);
    chk(cfg_q_o == 3'b000, "R1 config after reset", {29'b0, cfg_q_o}, 0);
    chk(!cfg_err_o, "R1 err after reset", {31'b0, cfg_err_o}, 0);

    // make two words pending before anything is registered
    foreach (word1[k]) begin
      set_en(word1[k], 1);
      for (int s = 0; s < 8; s++) if (pat(word1[k])[s]) raise(word1[k], s);
    end
    foreach (word0[k]) begin
      set_en(word0[k], 1);
      for (int s = 0; s < 8; s++) if (pat(word0[k])[s]) raise(word0[k], s);
    end
    idle_for(60, quiet);
    chk(quiet, "R1 nothing emitted before registration", {31'b0, quiet}, 1);

    // R3/R4: register only word 1, whole word seen in one snapshot
    do_reg(40, 9, 8'hA4);
    n = 0;
    foreach (word1[k]) for (int s = 0; s < 8; s++)
      if (pat(word1[k])[s]) begin exps[n] = exp_id(word1[k], s); n++; end
    for (int i = 0; i < n; i++) expect_one(exps[i], 1, "R4 ascending word1 / R5 packing");
    idle_for(60, quiet);
    chk(quiet, "R3 word0 outside bounds not emitted", {31'b0, quiet}, 1);

    // R3: widening bounds brings word 0 into the scan
    do_reg(17, 3, 8'h31);
    n = 0;
    foreach (word0[k]) for (int s = 0; s < 8; s++)
      if (pat(word0[k])[s]) begin exps[n] = exp_id(word0[k], s); n++; end
    for (int i = 0; i < n; i++) expect_one(exps[i], 1, "R3 R4 word0 after widening");

    // R5: sweep of every accumulator and source
    for (int a = 0; a < NA; a++) do_reg(a, (a * 5) & 15, (a * 11 + 7) & 255);
    for (int a = 0; a < NA; a++) set_en(a, 1);
    for (int a = 0; a < NA; a++) begin
      for (int s = 0; s < 8; s++) begin
        raise(a, s);
        expect_one(exp_id(a, s), 1, "R5 sweep");
        idle_for(4, quiet);
        chk(quiet, "R7 cleared source stays quiet", {31'b0, quiet}, 1);
      end
    end

    // R2: masked accumulator gated, unmask releases it
    set_en(20, 0);
    raise(20, 6);
    idle_for(60, quiet);
    chk(quiet, "R2 masked not emitted", {31'b0, quiet}, 1);
    set_en(20, 0);
    idle_for(20, quiet);
    chk(quiet, "R2 repeated mask keeps gate", {31'b0, quiet}, 1);
    set_en(20, 1);
    set_en(20, 1);
    expect_one(exp_id(20, 6), 1, "R2 unmask releases");

    // R7: clear before enable removes source; same-cycle raise wins
    set_en(21, 0);
    raise(21, 4);
    clr(21, 8'h10);
    set_en(21, 1);
    idle_for(60, quiet);
    chk(quiet, "R7 cleared not emitted", {31'b0, quiet}, 1);
    set_en(21, 0);
    raise_i = 1; raise_acc_i = 6'd21; raise_sel_i = 3'd4;
    clr_wr_i = 1; clr_acc_i = 6'd21; clr_mask_i = 8'h10;
    @(negedge clk); raise_i = 0; clr_wr_i = 0;
    set_en(21, 1);
    expect_one(exp_id(21, 4), 1, "R7 raise beats clear");

    // R8: uncleared source comes back on the next pass
    raise(22, 0);
    expect_one(exp_id(22, 0), 0, "R8 first pass");
    expect_one(exp_id(22, 0), 1, "R8 restart re-emits");
    idle_for(30, quiet);
    chk(quiet, "R8 quiet after clear", {31'b0, quiet}, 1);

    // R6: back-pressure holds the identifier
    begin
      bit seen;
      raise(23, 7);
      wait_valid(seen, 300);
      chk(seen, "R6 valid", {31'b0, seen}, 1);
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        chk(id_valid_o && id_o == exp_id(23, 7), "R6 held under stall", id_o, exp_id(23, 7));
      end
      expect_one(exp_id(23, 7), 1, "R6 accepted after stall");
      idle_for(10, quiet);
      chk(quiet, "R6 single id per handshake", {31'b0, quiet}, 1);
    end

    // R9: every configuration combination
    cfg_write(1, 1, 0);
    cur = 3'b110;
    chk(cfg_q_o == cur, "R9 baseline", {29'b0, cfg_q_o}, {29'b0, cur});
    for (int c = 0; c < 8; c++) begin
      bit bad;
      bad = (c[2] == 0) && (c[1] == 1) && (c[0] == 1);
      cfg_write(c[2], c[1], c[0]);
      if (!bad) cur = 3'(c);
      chk(cfg_err_o == bad, "R9 reject flag", {31'b0, cfg_err_o}, {31'b0, bad});
      chk(cfg_q_o == cur, "R9 stored config", {29'b0, cfg_q_o}, {29'b0, cur});
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule